// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Band-Pass Filter

This block filters one channel of a speech-processor filter bank. It is a 17-tap band-pass FIR filter with fixed integer coefficients, and it uses no multiplier. Each accepted sample is pushed into a 17-deep delay line. The filter then forms the output over W+1 clock cycles, one bit slice per cycle and least significant slice first.

The coefficients are symmetric, so the two samples that share a coefficient are first added bit-serially, with one carry flip-flop for each pair. The eight pair bits of a slice are split into two groups of four. In each group the top bit does not address the table. Instead, a multiplexer uses it to choose between the three lower bits and their complements, and that 3-bit value addresses an 8-word table of offset-coded coefficient sums. The same top bit, combined with the sign-slice flag, chooses whether the looked-up word is added or subtracted. The centre tap is not in the tables: its coefficient comes from a constant of its own and is added whenever the current bit of the centre sample is set. The sum for each slice goes into a right-shifting accumulator. That accumulator starts from a constant that removes the offset introduced by the table coding.

A caller waits for `busy` to go low, then presents a sample with `in_valid`. The result appears on `out_y` while `out_done` is high. Samples are signed two's complement. The output is exact for every input pattern.

Top module: `da_fir17`

## Requirements
- R1: A synchronous reset clears the delay line and leaves `busy`, `out_done` and `out_y` at zero. The first result after reset therefore equals c0 times that first sample.
- R2: A sample on `in_sample` is accepted at a rising edge where `in_valid` is 1 and `busy` is 0. The accepted sample becomes x[0] and the older samples move up by one position. The result is y = sum over i of c(i)*x[i] for i = 0..16, with c(i) = c(16-i) and c(8) the centre tap. The coefficients are packed in `COEFS` with c0 in the lowest CW bits, and c8 in the highest.
- R3: `out_done` goes high in the cycle after the 9th rising edge that follows the accepting edge (W+1 = 9 edges for W = 8).
- R4: `busy` is 1 from the cycle after an accepting edge until `out_done` rises, and `busy` is 0 whenever `out_done` is 1.
- R5: An `in_valid` pulse while `busy` is 1 is ignored. The delay line and the result in progress are unchanged.
- R6: `out_done` is high for exactly one cycle per accepted sample, and `out_y` carries the signed result during that cycle.
- R7: A sample presented in the cycle where `out_done` is high is accepted. Its result follows with the same latency as in R3.
- R8: Full-scale patterns produce the exact result with no overflow: all samples -128, all samples +127, and each sample at the extreme that has the sign of its coefficient.
- R9: Negative and mixed-sign samples give exact results. The most significant slice is subtracted, and the symmetric pair sums keep their ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, taken only while not busy |
| in_sample | input | W | Signed two's complement input sample |
| busy | output | 1 | High while the bit slices of the current output are processed |
| out_done | output | 1 | One-cycle strobe marking a valid result |
| out_y | output | OW | Signed filter output, valid with `out_done` |

## Verification
Two events can fall in the same cycle: the cycle in which one result is presented with `out_done`, and the acceptance of the next sample. The bench provokes this by driving the next sample in the exact cycle where it sees `out_done`, and it does so for most consecutive samples in a long run of seeded random values. It then checks three things: the presented result still matches the reference sum, the new sample appears in the following result, and the latency of that following result is unchanged. Junk strobes during busy cycles are mixed in, and the bench judges them by confirming that the next output leaves those values out.

// File: rtl/da_fir17.sv
module da_fir17 #(
  parameter int W  = 8,
  parameter int CW = 10,
  parameter logic [9*CW-1:0] COEFS = {10'sd150, -10'sd40, -10'sd71, -10'sd6, 10'sd18,
                                      10'sd2, -10'sd12, -10'sd9, -10'sd3},
  parameter int OW = W + CW + 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_sample,
  output logic                 busy,
  output logic                 out_done,
  output logic signed [OW-1:0] out_y
);
  localparam int N   = W + 1;
  localparam int CBW = $clog2(N + 1);
  localparam int IW  = (W > 1) ? $clog2(W) : 1;
  localparam int AW  = OW + N + 2;

  function automatic logic signed [AW-1:0] cf(input int i);
    logic signed [CW-1:0] c;
    c = COEFS[i*CW +: CW];
    return AW'(c);
  endfunction

  function automatic logic signed [AW-1:0] pair_sum();
    logic signed [AW-1:0] s;
    s = '0;
    for (int k = 0; k < 8; k++) s = s + cf(k);
    return s;
  endfunction

  function automatic logic signed [AW-1:0] dtab(input int g, input logic [2:0] u);
    logic signed [AW-1:0] s;
    s = -cf(4*g + 3);
    for (int i = 0; i < 3; i++) s = u[i] ? s + cf(4*g + i) : s - cf(4*g + i);
    return s;
  endfunction

  localparam logic signed [AW-1:0] INIT = (-pair_sum()) <<< (N - 1);
  localparam logic signed [AW-1:0] CTR2 = cf(8) <<< 1;

  logic signed [W-1:0]  dl [17];
  logic [7:0]           cy, cn, pb;
  logic [CBW-1:0]       cnt;
  logic [IW-1:0]        bi;
  logic                 ts, cb;
  logic signed [AW-1:0] acc, acc_nx, v;
  logic signed [AW-1:0] term [2];
  logic [2:0]           addr [2];

  assign bi = (cnt >= CBW'(W - 1)) ? IW'(W - 1) : IW'(cnt);
  assign ts = (cnt == CBW'(N - 1));
  assign cb = dl[8][bi];

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      pb[k] = dl[k][bi] ^ dl[16-k][bi] ^ cy[k];
      cn[k] = (dl[k][bi] & dl[16-k][bi]) | (cy[k] & (dl[k][bi] ^ dl[16-k][bi]));
    end
  end

  always_comb begin
    for (int g = 0; g < 2; g++) begin
      addr[g] = pb[4*g+3] ? ~pb[4*g +: 3] : pb[4*g +: 3];
      term[g] = (pb[4*g+3] ^ ts) ? -dtab(g, addr[g]) : dtab(g, addr[g]);
    end
  end

  assign v      = term[0] + term[1] + (cb ? (ts ? -CTR2 : CTR2) : '0);
  assign acc_nx = ((cnt == '0) ? INIT : (acc >>> 1)) + (v <<< (N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 17; i++) dl[i] <= '0;
      cy       <= '0;
      cnt      <= '0;
      acc      <= '0;
      busy     <= 1'b0;
      out_done <= 1'b0;
      out_y    <= '0;
    end else begin
      out_done <= 1'b0;
      if (!busy && in_valid) begin
        for (int i = 16; i > 0; i--) dl[i] <= dl[i-1];
        dl[0] <= in_sample;
        busy  <= 1'b1;
        cnt   <= '0;
        cy    <= '0;
      end else if (busy) begin
        acc <= acc_nx;
        cy  <= cn;
        cnt <= cnt + 1'b1;
        if (ts) begin
          busy     <= 1'b0;
          out_done <= 1'b1;
          out_y    <= OW'(acc_nx >>> 1);
        end
      end
    end
  end
endmodule

// File: rtl/da_fir17_chk.sv
module da_fir17_chk #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic busy,
  input logic out_done
);
  localparam int N = W + 1;
  logic [7:0] lat;

  always_ff @(posedge clk) begin
    if (rst) lat <= '0;
    else if (in_valid && !busy) lat <= 8'd1;
    else if (busy) lat <= lat + 8'd1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !out_done));
  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (lat == 8'(N + 1)));
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> !busy);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || out_done));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);
endmodule

bind da_fir17 da_fir17_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy), .out_done(out_done)
);

// File: tb/da_fir17_tb.sv
module da_fir17_tb;
  localparam int W = 8, CW = 10, OW = W + CW + 5;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic busy, out_done;
  logic signed [OW-1:0] out_y;
  int hist [17];
  int cset [9] = '{-3, -9, -12, 2, 18, -6, -71, -40, 150};
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  da_fir17 u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
                  .busy(busy), .out_done(out_done), .out_y(out_y));

  function automatic int cof(int i);
    return cset[(i <= 8) ? i : 16 - i];
  endfunction

  function automatic int model_y();
    int s = 0;
    for (int i = 0; i < 17; i++) s += cof(i) * hist[i];
    return s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at the current negedge, wait for out_done, check. Leaves time at the done negedge.
  task automatic run(int x, string tag, bit junk);
    int k;
    in_valid  = 1'b1;
    in_sample = W'(x);
    for (int i = 16; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy == 1'b1, "R4 busy after accept", int'(busy), 1);
    k = 1;
    while (!out_done && k < 40) begin
      if (junk && k == 3) begin
        in_valid  = 1'b1;
        in_sample = W'($urandom_range(255));
      end
      @(negedge clk);
      in_valid = 1'b0;
      k++;
    end
    chk(k == W + 2, "R3 latency", k, W + 2);
    chk(busy == 1'b0, "R4 idle at done", int'(busy), 0);
    chk(int'(out_y) == model_y(), junk ? "R5 ignored strobe" : tag, int'(out_y), model_y());
  endtask

  task automatic gap();
    @(negedge clk);
    chk(out_done == 1'b0, "R6 single pulse", int'(out_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 17; i++) hist[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && out_done == 0 && out_y == 0, "R1 reset state",
        int'(busy) + int'(out_done) + int'(out_y), 0);
    run(100, "R1 first result", 1'b0);
    gap();
    run(-77, "R2 second sample", 1'b0);
    run(55, "R7 accepted in done cycle", 1'b0);
    run(-128, "R7 chained", 1'b0);
    gap();
    run(33, "R5", 1'b1);
    gap();
    for (int i = 0; i < 17; i++) run(-128, "R8 all min", 1'b0);
    for (int i = 0; i < 17; i++) run(127, "R8 all max", 1'b0);
    for (int i = 16; i >= 0; i--) run((cof(i) >= 0) ? 127 : -128, "R8 sign matched", 1'b0);
    for (int i = 16; i >= 0; i--) run((cof(i) >= 0) ? -128 : 127, "R8 sign opposed", 1'b0);
    for (int i = 0; i < 150; i++) begin
      int x = int'($urandom_range(255)) - 128;
      bit j = ($urandom_range(7) == 0);
      run(x, "R9 random signed", j);
      if ($urandom_range(3) == 0) gap();
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 17; i++) hist[i] = 0;
    @(negedge clk);
    chk(busy == 0 && out_done == 0 && out_y == 0, "R1 reset mid-run",
        int'(busy) + int'(out_done) + int'(out_y), 0);
    run(-1, "R1 line cleared", 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule